// File: doc/BRIEF.md
# Control-Flow Edge Queue with Recent-Edge Filter

This block sits beside a processor core and collects the taken control-flow edges the core reports. Each edge is a source address and a target address. Edges wait in a short pending queue until they are validated, either by the local core or by a peer core that has spare capacity. A small store keeps the edges that were validated most recently. An arriving edge that is already in that store is dropped, so an edge seen again inside a tight loop is not validated twice.

The block counts how long each pending edge has waited. It raises an urgency flag when the queue is full or when the oldest edge has waited longer than a programmable limit. The local core then pops that edge and checks it itself. While the peer reports idle, the block pops the oldest edge on its own and presents it on a handoff port, together with a one-cycle request. The lookup against the golden edge table is done outside this block.

Top module: `cf_edge_queue`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1 and `head_valid`, `urgent` and `hand_req` are 0.
- R2: Accepted edges leave the pending queue oldest first. `head_src` and `head_dst` show the oldest edge whenever `head_valid` is 1, and `local_pop` removes it.
- R3: The pending queue holds 5 edges. `in_ready` is 0 when the queue is full and no pop happens in that cycle. When an arrival and a pop happen in the same cycle, both take effect.
- R4: An edge offered with `in_valid` and `in_ready` is discarded without being queued when both its source and its target equal those of a valid history entry. Edges reported on `done_valid` enter the history. An arrival is compared only against entries written in earlier cycles.
- R5: The history keeps the 5 most recently reported edges. A sixth report evicts the oldest one, and that edge is accepted into the queue again.
- R6: `urgent` is 1 whenever the pending queue is full.
- R7: Each pending edge has an 8-bit age. The age is 0 right after the edge is written, rises by one per clock and saturates at 255. `urgent` is 1 when the oldest edge's age is greater than `age_limit`.
- R8: When `peer_idle` is 1, the queue is not empty and `local_pop` is 0, the oldest edge is popped. In the next cycle `hand_req` is 1 for one cycle, and `hand_src` and `hand_dst` carry that edge.
- R9: `local_pop` wins over a peer handoff in the same cycle, so no handoff request follows. A pop of either kind has no effect on an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Core offers an edge |
| in_src | input | 32 | Source address of the offered edge |
| in_dst | input | 32 | Target address of the offered edge |
| in_ready | output | 1 | Queue can take an edge this cycle |
| age_limit | input | 8 | Waiting-time limit in cycles |
| local_pop | input | 1 | Local core takes the oldest edge |
| head_valid | output | 1 | Queue holds at least one edge |
| head_src | output | 32 | Source address of the oldest edge |
| head_dst | output | 32 | Target address of the oldest edge |
| urgent | output | 1 | Oldest edge must be validated locally now |
| peer_idle | input | 1 | Peer core has spare capacity |
| hand_req | output | 1 | Processing request to the peer, one cycle |
| hand_src | output | 32 | Source address handed to the peer |
| hand_dst | output | 32 | Target address handed to the peer |
| done_valid | input | 1 | An edge was validated successfully |
| done_src | input | 32 | Source address of the validated edge |
| done_dst | input | 32 | Target address of the validated edge |

## Verification
The filter is tested with four kinds of arrival:
- an edge already in the history, which must be dropped;
- a fresh edge, which must be queued;
- an edge reported as validated in the same cycle it arrives, which must still be queued because only older history entries count;
- an edge evicted by a sixth history report, which must be queued again.

The queue is tested with three ways of emptying it: local pops only, peer handoffs only, and both requested in the same cycle. These show whether ordering, handoff timing and priority are correct. A full queue is tested with and without a simultaneous pop, which shows whether back-pressure and the same-cycle push/pop rule are kept apart. An age limit of 3 shows whether the urgency flag rises exactly one cycle after the limit is passed.

// File: rtl/cfq_pkg.sv
package cfq_pkg;
  parameter int unsigned CFQ_AW = 32;

  typedef struct packed {
    logic [CFQ_AW-1:0] src;
    logic [CFQ_AW-1:0] dst;
  } cfq_edge_t;
endpackage

// File: rtl/cfq_pend_fifo.sv
module cfq_pend_fifo
  import cfq_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned AGE_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  cfq_edge_t        wr_edge,
  input  logic             rd_en,
  output cfq_edge_t        head_edge,
  output logic [AGE_W-1:0] head_age,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full
);
  cfq_edge_t        mem [DEPTH];
  logic [AGE_W-1:0] age_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // per-slot waiting counters, cleared on write, saturating
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)
        age_q[i] <= '0;
      else if (wr_en && wr_ptr == PTR_W'(i))
        age_q[i] <= '0;
      else if (age_q[i] != '1)
        age_q[i] <= age_q[i] + 1'b1;
    end
  end

  assign head_edge = mem[rd_ptr];
  assign head_age  = age_q[rd_ptr];
  assign empty     = (cnt == '0);
  assign full      = (cnt == CNT_W'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  // R3
  full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |-> rd_en);
  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/cfq_hist_cam.sv
module cfq_hist_cam
  import cfq_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  cfq_edge_t push_edge,
  input  cfq_edge_t probe_edge,
  output logic      hit
);
  cfq_edge_t        mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (push) mem[ptr] <= push_edge;
  end

  // circular write pointer: the slot it points at is always the oldest
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else if (push) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld[g] && (mem[g] == probe_edge);
  end

  assign hit = |match;

  // R5
  hist_keep_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> ($countones(vld) >= $past($countones(vld))));
endmodule

// File: rtl/cf_edge_queue.sv
module cf_edge_queue
  import cfq_pkg::*;
#(
  parameter int unsigned PEND_DEPTH = 5,
  parameter int unsigned HIST_DEPTH = 5,
  parameter int unsigned AGE_W      = 8,
  localparam int unsigned CNT_W = $clog2(PEND_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CFQ_AW-1:0] in_src,
  input  logic [CFQ_AW-1:0] in_dst,
  output logic              in_ready,
  input  logic [AGE_W-1:0]  age_limit,
  input  logic              local_pop,
  output logic              head_valid,
  output logic [CFQ_AW-1:0] head_src,
  output logic [CFQ_AW-1:0] head_dst,
  output logic              urgent,
  input  logic              peer_idle,
  output logic              hand_req,
  output logic [CFQ_AW-1:0] hand_src,
  output logic [CFQ_AW-1:0] hand_dst,
  input  logic              done_valid,
  input  logic [CFQ_AW-1:0] done_src,
  input  logic [CFQ_AW-1:0] done_dst
);
  cfq_edge_t        arr_edge, done_edge, head_edge;
  logic [AGE_W-1:0] head_age;
  logic [CNT_W-1:0] pend_cnt;
  logic             empty, full, hist_hit;
  logic             pop_local, pop_peer, pop_any, wr_en;

  assign arr_edge  = '{src: in_src, dst: in_dst};
  assign done_edge = '{src: done_src, dst: done_dst};

  assign pop_local = local_pop && !empty;
  assign pop_peer  = peer_idle && !empty && !local_pop;
  assign pop_any   = pop_local || pop_peer;
  assign in_ready  = !full || pop_any;
  assign wr_en     = in_valid && in_ready && !hist_hit;

  cfq_pend_fifo #(.DEPTH(PEND_DEPTH), .AGE_W(AGE_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_edge   (arr_edge),
    .rd_en     (pop_any),
    .head_edge (head_edge),
    .head_age  (head_age),
    .cnt       (pend_cnt),
    .empty     (empty),
    .full      (full)
  );

  cfq_hist_cam #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .push       (done_valid),
    .push_edge  (done_edge),
    .probe_edge (arr_edge),
    .hit        (hist_hit)
  );

  // handoff register toward the peer
  always_ff @(posedge clk) begin
    if (rst) begin
      hand_req <= 1'b0;
      hand_src <= '0;
      hand_dst <= '0;
    end else begin
      hand_req <= pop_peer;
      if (pop_peer) begin
        hand_src <= head_edge.src;
        hand_dst <= head_edge.dst;
      end
    end
  end

  assign head_valid = !empty;
  assign head_src   = head_edge.src;
  assign head_dst   = head_edge.dst;
  assign urgent     = full || (!empty && (head_age > age_limit));

  // R4
  hit_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && hist_hit && !pop_any) |=> (pend_cnt == $past(pend_cnt)));
  // R6
  full_urgent_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_cnt == CNT_W'(PEND_DEPTH)) |-> urgent);
  // R8
  handoff_src_chk: assert property (@(posedge clk) disable iff (rst)
    hand_req |-> ($past(peer_idle) && !$past(local_pop)));
  // R8
  handoff_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_peer && pend_cnt == CNT_W'(1) && !wr_en) |=> (hand_req && !head_valid));
endmodule

// File: tb/sim_cf_edge_queue.sv
module sim_cf_edge_queue;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, local_pop, peer_idle, done_valid;
  logic [31:0] in_src, in_dst, done_src, done_dst;
  logic [7:0]  age_limit;
  logic        in_ready, head_valid, urgent, hand_req;
  logic [31:0] head_src, head_dst, hand_src, hand_dst;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cf_edge_queue u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_dst(in_dst),
    .in_ready(in_ready), .age_limit(age_limit), .local_pop(local_pop),
    .head_valid(head_valid), .head_src(head_src), .head_dst(head_dst),
    .urgent(urgent), .peer_idle(peer_idle), .hand_req(hand_req),
    .hand_src(hand_src), .hand_dst(hand_dst), .done_valid(done_valid),
    .done_src(done_src), .done_dst(done_dst)
  );

  function automatic logic [31:0] sa(input int i);
    return 32'h0000_1000 + 32'(i) * 4;
  endfunction
  function automatic logic [31:0] da(input int i);
    return 32'h0008_0000 + 32'(i) * 16;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 0; local_pop = 0; peer_idle = 0; done_valid = 0;
    in_src = 0; in_dst = 0; done_src = 0; done_dst = 0; age_limit = 8'd255;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic push(input int i);
    in_valid = 1; in_src = sa(i); in_dst = da(i);
    step();
    in_valid = 0;
  endtask

  task automatic lpop();
    local_pop = 1;
    step();
    local_pop = 0;
  endtask

  task automatic report(input int i);
    done_valid = 1; done_src = sa(i); done_dst = da(i);
    step();
    done_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    chk("R1 head_valid", 64'(head_valid), 64'd0);
    chk("R1 urgent", 64'(urgent), 64'd0);
    chk("R1 hand_req", 64'(hand_req), 64'd0);
  endtask

  task automatic t_order();
    do_reset();
    push(1); push(2); push(3);
    for (int k = 1; k <= 3; k++) begin
      chk("R2 head src", 64'(head_src), 64'(sa(k)));
      chk("R2 head dst", 64'(head_dst), 64'(da(k)));
      lpop();
    end
    chk("R2 drained", 64'(head_valid), 64'd0);
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 10; k < 15; k++) push(k);
    chk("R3 ready low when full", 64'(in_ready), 64'd0);
    chk("R6 urgent when full", 64'(urgent), 64'd1);
    in_valid = 1; in_src = sa(15); in_dst = da(15); local_pop = 1;
    #1;
    chk("R3 ready with pop", 64'(in_ready), 64'd1);
    step();
    in_valid = 0; local_pop = 0;
    chk("R3 head after push+pop", 64'(head_src), 64'(sa(11)));
    chk("R6 still full", 64'(urgent), 64'd1);
    for (int k = 11; k <= 15; k++) begin
      chk("R3 drain order", 64'(head_dst), 64'(da(k)));
      lpop();
    end
    chk("R3 empty after drain", 64'(head_valid), 64'd0);
  endtask

  task automatic t_hist();
    do_reset();
    report(20);
    push(20);
    chk("R4 known edge dropped", 64'(head_valid), 64'd0);
    in_valid = 1; in_src = sa(20); in_dst = da(21);
    step(); in_valid = 0;
    chk("R4 partial match queued", 64'(head_dst), 64'(da(21)));
    lpop();
    in_valid = 1; in_src = sa(22); in_dst = da(22);
    done_valid = 1; done_src = sa(22); done_dst = da(22);
    step(); in_valid = 0; done_valid = 0;
    chk("R4 same-cycle report not a match", 64'(head_src), 64'(sa(22)));
    lpop();
    push(22);
    chk("R4 later arrival dropped", 64'(head_valid), 64'd0);
  endtask

  task automatic t_evict();
    do_reset();
    for (int k = 30; k < 36; k++) report(k);
    push(30);
    chk("R5 evicted edge queued", 64'(head_src), 64'(sa(30)));
    lpop();
    push(31);
    chk("R5 kept edge dropped", 64'(head_valid), 64'd0);
    push(35);
    chk("R5 newest edge dropped", 64'(head_valid), 64'd0);
  endtask

  task automatic t_age();
    do_reset();
    age_limit = 8'd3;
    push(40);
    step(); step(); step();
    chk("R7 age at limit not urgent", 64'(urgent), 64'd0);
    step();
    chk("R7 age over limit urgent", 64'(urgent), 64'd1);
    push(41);
    lpop();
    chk("R7 younger head not urgent", 64'(urgent), 64'd0);
    age_limit = 8'd255;
    for (int k = 0; k < 300; k++) step();
    chk("R7 saturated age vs 255", 64'(urgent), 64'd0);
    age_limit = 8'd254;
    #1;
    chk("R7 saturated age vs 254", 64'(urgent), 64'd1);
  endtask

  task automatic t_peer();
    do_reset();
    push(50); push(51);
    peer_idle = 1;
    step();
    chk("R8 hand_req first", 64'(hand_req), 64'd1);
    chk("R8 hand edge first", {hand_src, hand_dst}, {sa(50), da(50)});
    chk("R8 head advanced", 64'(head_src), 64'(sa(51)));
    step();
    chk("R8 hand edge second", {hand_src, hand_dst}, {sa(51), da(51)});
    chk("R8 queue empty", 64'(head_valid), 64'd0);
    step();
    chk("R8 no request on empty", 64'(hand_req), 64'd0);
    peer_idle = 0;
  endtask

  task automatic t_prio();
    do_reset();
    push(60); push(61);
    peer_idle = 1; local_pop = 1;
    step();
    peer_idle = 0; local_pop = 0;
    chk("R9 local wins no handoff", 64'(hand_req), 64'd0);
    chk("R9 one pop only", 64'(head_src), 64'(sa(61)));
    lpop();
    lpop();
    chk("R9 pop on empty harmless", 64'(head_valid), 64'd0);
    peer_idle = 1;
    step();
    peer_idle = 0;
    chk("R9 peer on empty no request", 64'(hand_req), 64'd0);
    push(62);
    chk("R9 queue intact", 64'(head_src), 64'(sa(62)));
    lpop();
    chk("R9 count intact", 64'(head_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_full();
    t_hist();
    t_evict();
    t_age();
    t_peer();
    t_prio();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (R1..R9 run hung): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule